// File: doc/BRIEF.md
# Pulse-Mode Conversion Start Sequencer

This block sequences single conversions for a delta-sigma converter that runs in pulse mode. A conversion begins when the start pin rises or when the serial port decoder raises a one-cycle start pulse. The block then waits a coded power-of-two number of master clocks. It pulses the decimation filter reset for one clock and counts out the filter settling time, which is one conversion cycle for the first-order filter and two for the second-order filter. Because of that wait, the first result is already settled and no sample has to be discarded.

When settling ends, the active-low data-ready output falls and the sequencer halts until the next trigger. A trigger that arrives mid-conversion restarts the sequence from the delay phase. The delay code and the filter order are sampled at the trigger.

Top module: `pulse_conv_seq`

## Requirements
- R1: While `rst_ni` is low, and after any reset, `busy_o` is 0, `filt_rst_o` is 0 and `drdy_n_o` is 1, even when reset cuts a conversion short.
- R2: A high `cmd_start_i` sampled at a clock edge starts a conversion: from that edge `busy_o` is 1 and `drdy_n_o` is 1.
- R3: A rising edge on `start_pin_i` starts a conversion after a `SYNC_STAGES`-flop synchronizer: `busy_o` first reads 1 at the `SYNC_STAGES+1`-th clock after the pin rises. Holding the pin high does not start further conversions, and a falling pin has no effect.
- R4: Delay code 0 gives no pre-conversion wait. Code k in 1..7 gives `DELAY_BASE * 2^(k-1)` master clocks, which is 64, 128 and so on up to 4096 with the default.
- R5: `filt_rst_o` is high for exactly one clock per conversion. That clock is D clocks after the starting edge, where D is the decoded delay.
- R6: `filt_ord_i` = 0 selects a settling time of `CYCLE_CLKS` clocks and 1 selects `2*CYCLE_CLKS`. `drdy_n_o` falls, and `busy_o` falls with it, exactly D + 1 + settle clocks after the starting edge.
- R7: After a conversion completes, `busy_o` stays 0 and `drdy_n_o` stays 0 until the next trigger.
- R8: A trigger during a conversion restarts the sequence from the delay phase, with timing measured from the new trigger. It does not queue another conversion, and `drdy_n_o` stays 1 until the restarted conversion ends.
- R9: The delay code and filter order are captured at the trigger. Changing `delay_code_i` or `filt_ord_i` during a conversion does not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_pin_i | input | 1 | Asynchronous start pin, rising edge triggers |
| cmd_start_i | input | 1 | One-cycle start pulse from the command decoder, synchronous to clk_i |
| delay_code_i | input | 3 | Pre-conversion delay code |
| filt_ord_i | input | 1 | Filter order select: 0 first order, 1 second order |
| filt_rst_o | output | 1 | One-clock decimation filter reset |
| busy_o | output | 1 | Conversion in progress, including the delay phase |
| drdy_n_o | output | 1 | Data ready, active low |

## Verification
The bench builds the block with `CYCLE_CLKS` = 20, keeping `DELAY_BASE` = 64 and `SYNC_STAGES` = 2. The short conversion cycle makes first-order and second-order settling differ by only 20 clocks. This brings every delay code up to the full 4096-clock wait, mid-conversion retriggers and input changes within a short run. Measuring exact counts from the start edge to the filter reset and to data ready separates the two settle lengths and all eight delay codes to the single clock.

// File: rtl/pulse_conv_seq_pkg.sv
package pulse_conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_FRST   = 2'd2,
    ST_SETTLE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pcs_start_detect.sv
module pcs_start_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic cmd_i,
  output logic trig_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  // rising edge of synchronized pin, or command pulse
  assign trig_o = (sync_q[SYNC_STAGES-1] & ~prev_q) | cmd_i;
endmodule

// File: rtl/pcs_delay_decode.sv
module pcs_delay_decode #(
  parameter int DELAY_BASE = 64,
  parameter int CW         = 13
) (
  input  logic [2:0]    code_i,
  output logic [CW-1:0] clks_o
);
  always_comb begin
    clks_o = '0;
    for (int k = 1; k < 8; k++) begin
      if (code_i == k[2:0]) clks_o = CW'(DELAY_BASE << (k - 1));
    end
  end
endmodule

// File: rtl/pcs_timer.sv
module pcs_timer #(
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pulse_conv_seq.sv
module pulse_conv_seq
  import pulse_conv_seq_pkg::*;
#(
  parameter int DELAY_BASE  = 64,
  parameter int CYCLE_CLKS  = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_pin_i,
  input  logic       cmd_start_i,
  input  logic [2:0] delay_code_i,
  input  logic       filt_ord_i,
  output logic       filt_rst_o,
  output logic       busy_o,
  output logic       drdy_n_o
);
  localparam int MAX_DLY = DELAY_BASE * 64;
  localparam int MAX_SET = 2 * CYCLE_CLKS;
  localparam int MAX_CNT = (MAX_DLY > MAX_SET) ? MAX_DLY : MAX_SET;
  localparam int CW      = $clog2(MAX_CNT + 1);
  localparam logic [CW-1:0] SET1_M1 = CW'(CYCLE_CLKS - 1);
  localparam logic [CW-1:0] SET2_M1 = CW'(2 * CYCLE_CLKS - 1);

  seq_state_e    st_q, st_d;
  logic          trig;
  logic          ord_q;
  logic          drdy_n_q;
  logic [CW-1:0] dly_clks;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;

  pcs_start_detect #(.SYNC_STAGES(SYNC_STAGES)) i_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (start_pin_i),
    .cmd_i  (cmd_start_i),
    .trig_o (trig)
  );

  pcs_delay_decode #(.DELAY_BASE(DELAY_BASE), .CW(CW)) i_dec (
    .code_i (delay_code_i),
    .clks_o (dly_clks)
  );

  pcs_timer #(.CW(CW)) i_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (trig) begin
      // any trigger restarts from the delay phase
      if (dly_clks == '0) begin
        st_d = ST_FRST;
      end else begin
        st_d     = ST_DELAY;
        tmr_load = 1'b1;
        tmr_val  = dly_clks - CW'(1);
      end
    end else begin
      unique case (st_q)
        ST_DELAY:  if (tmr_zero) st_d = ST_FRST;
        ST_FRST: begin
          st_d     = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = ord_q ? SET2_M1 : SET1_M1;
        end
        ST_SETTLE: if (tmr_zero) st_d = ST_IDLE;
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ord_q    <= 1'b0;
      drdy_n_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (trig) begin
        ord_q    <= filt_ord_i;
        drdy_n_q <= 1'b1;
      end else if (st_q == ST_SETTLE && tmr_zero) begin
        drdy_n_q <= 1'b0;
      end
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign filt_rst_o = (st_q == ST_FRST);
  assign drdy_n_o   = drdy_n_q;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic trig_i,
  input logic busy_i,
  input logic filt_rst_i,
  input logic drdy_n_i
);
  a_r2_trig_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (busy_i && drdy_n_i));

  a_r5_frst_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    filt_rst_i |-> busy_i);

  a_r5_frst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_rst_i && !trig_i) |=> !filt_rst_i);

  a_r6_ready_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> !drdy_n_i);

  a_r6_ready_only_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_n_i) |-> $fell(busy_i));

  a_r7_halt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !trig_i) |=> !busy_i);

  a_r8_not_ready_in_conv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> drdy_n_i);
endmodule

bind pulse_conv_seq pcs_checker i_pcs_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trig_i     (trig),
  .busy_i     (busy_o),
  .filt_rst_i (filt_rst_o),
  .drdy_n_i   (drdy_n_o)
);

// File: tb/test_pulse_conv_seq.sv
module test_pulse_conv_seq;
  localparam int DBASE = 64;
  localparam int CYC   = 20;
  localparam int SYNC  = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_pin_i = 1'b0;
  logic       cmd_start_i = 1'b0;
  logic [2:0] delay_code_i = 3'd0;
  logic       filt_ord_i = 1'b0;
  logic       filt_rst_o, busy_o, drdy_n_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pulse_conv_seq #(.DELAY_BASE(DBASE), .CYCLE_CLKS(CYC), .SYNC_STAGES(SYNC)) i_pulse_conv_seq (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .start_pin_i  (start_pin_i),
    .cmd_start_i  (cmd_start_i),
    .delay_code_i (delay_code_i),
    .filt_ord_i   (filt_ord_i),
    .filt_rst_o   (filt_rst_o),
    .busy_o       (busy_o),
    .drdy_n_o     (drdy_n_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: act cycles=%0d exp < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int exp_delay(input int code);
    return (code == 0) ? 0 : (DBASE << (code - 1));
  endfunction

  function automatic int exp_settle(input bit ord);
    return ord ? 2 * CYC : CYC;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_cmd();
    @(negedge clk) cmd_start_i = 1'b1;
    @(negedge clk) cmd_start_i = 1'b0;
  endtask

  task automatic pin_start();
    int n = 0;
    @(negedge clk) start_pin_i = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!busy_o && n < 10);
    check(n == SYNC + 1, "R3 pin start latency", n, SYNC + 1);
  endtask

  // called at the first negedge after the trigger edge
  task automatic measure(input int code, input bit ord, input bit perturb);
    int d     = exp_delay(code);
    int tot   = d + 1 + exp_settle(ord);
    int cnt   = 0;
    int fr_n  = 0;
    int fr_at = -1;
    check(busy_o && drdy_n_o, "R2 start state", {busy_o, drdy_n_o}, 3);
    if (filt_rst_o) begin fr_n++; fr_at = 0; end
    while (drdy_n_o && cnt < tot + 10) begin
      @(negedge clk);
      cnt++;
      if (perturb && cnt == 2) begin
        delay_code_i = ~3'(code);
        filt_ord_i   = !ord;
      end
      if (filt_rst_o) begin fr_n++; fr_at = cnt; end
    end
    check(fr_n == 1, "R5 filter reset pulses", fr_n, 1);
    check(fr_at == d, "R4 delay before filter reset", fr_at, d);
    check(cnt == tot, perturb ? "R9 timing after input change" : "R6 start-to-ready", cnt, tot);
    check(!busy_o, "R6 busy ends with ready", busy_o, 0);
  endtask

  task automatic check_halt(input int n, input string req);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (busy_o || drdy_n_o) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  task automatic conv(input bit via_pin, input int code, input bit ord, input bit perturb);
    @(negedge clk);
    delay_code_i = 3'(code);
    filt_ord_i   = ord;
    if (via_pin) pin_start();
    else         pulse_cmd();
    measure(code, ord, perturb);
    check_halt(30, via_pin ? "R3 held pin no restart" : "R7 halt after result");
    if (via_pin) begin
      start_pin_i = 1'b0;
      check_halt(10, "R3 falling pin ignored");
    end
  endtask

  initial begin
    void'($urandom(32'd1259));
    repeat (3) @(negedge clk);
    check(!busy_o && !filt_rst_o && drdy_n_o, "R1 reset outputs",
          {busy_o, filt_rst_o, drdy_n_o}, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && drdy_n_o, "R1 idle after reset", {busy_o, drdy_n_o}, 1);

    // directed corners
    conv(1'b0, 0, 1'b0, 1'b0);
    conv(1'b0, 0, 1'b1, 1'b0);
    conv(1'b0, 1, 1'b0, 1'b0);
    conv(1'b1, 7, 1'b1, 1'b0);
    conv(1'b0, 3, 1'b1, 1'b1);

    // R8 retrigger mid-conversion
    @(negedge clk);
    delay_code_i = 3'd2;
    filt_ord_i   = 1'b1;
    pulse_cmd();
    repeat (40) @(negedge clk);
    check(busy_o && drdy_n_o, "R8 first conversion running", {busy_o, drdy_n_o}, 3);
    delay_code_i = 3'd1;
    filt_ord_i   = 1'b0;
    pulse_cmd();
    measure(1, 1'b0, 1'b0);
    check_halt(200, "R8 no queued conversion");

    // R1 reset mid-conversion
    @(negedge clk);
    delay_code_i = 3'd0;
    filt_ord_i   = 1'b0;
    pulse_cmd();
    @(negedge clk) rst_ni = 1'b0;
    #1;
    check(!busy_o && !filt_rst_o && drdy_n_o, "R1 reset mid-conversion",
          {busy_o, filt_rst_o, drdy_n_o}, 1);
    @(negedge clk) rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    check(!busy_o, "R1 idle after mid reset", busy_o, 0);

    // random mix
    for (int i = 0; i < 20; i++) begin
      conv(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule